// File: doc/BRIEF.md
# Four-Input Scan Channel Sequencer

This block turns a compact scan-mode code into the sequence of channel numbers that a four-input acquisition front end attaches to its samples. Software writes a 16-bit configuration word. The low three bits pick the scan:

- one fixed channel;
- the lower pair (0 then 1);
- the upper pair (2 then 3);
- all four inputs in rising order.

On every sample tick the block emits the next channel of that scan. It raises a wrap pulse on the last channel of each pass. Code zero is treated as illegal: the block stays silent and raises a flag.

The same word carries one enable bit and one AC-coupling bit for each input pair. The block holds these bits and presents them as steady outputs for the analog side. A pair whose enable is low is grounded inside the front end. Rewriting the word restarts the scan, so the next tick always carries the first channel of the new mode.

Top module: `scan_seq`

## Requirements
- R1: While and after synchronous reset, with no write yet, `mode_bad` is 1, `ch_valid` and `scan_wrap` are 0, and `pair_en` and `pair_ac` are 0.
- R2: A mode code with bit 2 set (codes 4 to 7) scans the single channel given by code bits [1:0]. Every tick then emits that channel with `scan_wrap` set.
- R3: Mode code 2 emits channels 0, 1, 0, 1, ... on successive ticks.
- R4: Mode code 3 emits channels 2, 3, 2, 3, ... on successive ticks.
- R5: Mode code 1 emits channels 0, 1, 2, 3 and then repeats from 0.
- R6: Mode code 0 emits nothing on a tick (`ch_valid` stays 0) and holds `mode_bad` at 1. Every other code holds `mode_bad` at 0.
- R7: A configuration write restarts the scan, so the first tick after the write emits the first channel of the new mode. A tick in the same cycle as the write is emitted with the old mode and position.
- R8: `scan_wrap` is 1 exactly on the emission of the last channel of a scan, and never without `ch_valid`.
- R9: `pair_en[0]` holds word bit 7 (channels 0/1) and `pair_en[1]` holds word bit 8 (channels 2/3). Both change only on a write.
- R10: `pair_ac[0]` holds word bit 9 (AC coupling, pair 0/1) and `pair_ac[1]` holds word bit 10 (pair 2/3). Both change only on a write.
- R11: A tick at a clock edge produces a one-cycle emission (`ch_valid`, `ch_tag`, `scan_wrap`) in the cycle after that edge. Without a tick, `ch_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word: [2:0] mode, [8:7] pair enables, [10:9] pair AC coupling |
| tick | input | 1 | Sample tick, one emission per tick |
| ch_valid | output | 1 | Emission valid, one cycle after a tick |
| ch_tag | output | 2 | Channel number of this emission |
| scan_wrap | output | 1 | Emission is the last channel of the scan |
| mode_bad | output | 1 | Current mode code is illegal (code 0) |
| pair_en | output | 2 | Per-pair input enable |
| pair_ac | output | 2 | Per-pair AC coupling select |

## Verification
The hardest case to reach is a rewrite of the mode that lands partway through a scan. It is hardest of all when the write arrives in the same cycle as a tick, because the tick must still use the old mode while the next tick restarts at the new mode's first channel. A directed sequence makes this happen. It steps the all-four mode to channel 3, then writes the lower-pair mode together with a tick. After the directed part, a long pseudo-random run of sparse writes and ticks keeps colliding writes with scan positions in every mode. A behavioural queue-based model checks each emission.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    localparam int CFG_W     = 16;
    localparam int NUM_CH    = 4;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int NUM_PAIRS = NUM_CH / 2;
    localparam int MODE_LSB  = 0;
    localparam int MODE_W    = 3;
    localparam int EN_LSB    = 7;
    localparam int AC_LSB    = EN_LSB + NUM_PAIRS;

    typedef logic [CH_W-1:0]   chan_t;
    typedef logic [MODE_W-1:0] mode_t;

    typedef struct packed {
        logic        legal;
        chan_t       base;
        logic [CH_W:0] len;
    } scan_plan_t;

    typedef struct packed {
        logic  valid;
        chan_t tag;
        logic  wrap;
    } emit_t;

    function automatic scan_plan_t plan_from_code(input mode_t code);
        scan_plan_t p;
        p = '0;
        if (code[MODE_W-1]) begin
            p.legal = 1'b1;
            p.base  = code[CH_W-1:0];
            p.len   = (CH_W+1)'(1);
        end else begin
            case (code[1:0])
                2'd1: begin
                    p.legal = 1'b1;
                    p.base  = '0;
                    p.len   = (CH_W+1)'(NUM_CH);
                end
                2'd2: begin
                    p.legal = 1'b1;
                    p.base  = '0;
                    p.len   = (CH_W+1)'(2);
                end
                2'd3: begin
                    p.legal = 1'b1;
                    p.base  = chan_t'(2);
                    p.len   = (CH_W+1)'(2);
                end
                default: p = '0;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/scan_cfg_reg.sv
module scan_cfg_reg
    import scan_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [CFG_W-1:0]     wdata,
    output scan_plan_t           plan,
    output logic                 restart,
    output logic [NUM_PAIRS-1:0] pair_en,
    output logic [NUM_PAIRS-1:0] pair_ac
);

    mode_t                mode_q;
    logic [NUM_PAIRS-1:0] en_q;
    logic [NUM_PAIRS-1:0] ac_q;
    logic                 unused_bits;

    assign unused_bits = ^{wdata[CFG_W-1:AC_LSB+NUM_PAIRS],
                           wdata[EN_LSB-1:MODE_LSB+MODE_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            en_q   <= '0;
            ac_q   <= '0;
        end else if (we) begin
            mode_q <= wdata[MODE_LSB +: MODE_W];
            en_q   <= wdata[EN_LSB +: NUM_PAIRS];
            ac_q   <= wdata[AC_LSB +: NUM_PAIRS];
        end
    end

    assign plan    = plan_from_code(mode_q);
    assign restart = we;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        assign pair_en[g] = en_q[g];
        assign pair_ac[g] = ac_q[g];
    end

endmodule

// File: rtl/scan_walker.sv
module scan_walker
    import scan_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       restart,
    input  scan_plan_t plan,
    output emit_t      emit
);

    chan_t pos_q;
    emit_t emit_q;
    logic  fire;
    logic  last;

    assign fire = tick && plan.legal;
    assign last = ({1'b0, pos_q} == (plan.len - 1'b1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            emit_q <= '0;
        end else begin
            emit_q.valid <= fire;
            emit_q.tag   <= plan.base + pos_q;
            emit_q.wrap  <= fire && last;
            if (restart) begin
                pos_q <= '0;
            end else if (fire) begin
                pos_q <= last ? '0 : pos_q + 1'b1;
            end
        end
    end

    assign emit = emit_q;

endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import scan_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    input  logic        tick,
    output logic        ch_valid,
    output logic [1:0]  ch_tag,
    output logic        scan_wrap,
    output logic        mode_bad,
    output logic [1:0]  pair_en,
    output logic [1:0]  pair_ac
);

    scan_plan_t plan;
    logic       restart;
    emit_t      emit;

    scan_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .plan    (plan),
        .restart (restart),
        .pair_en (pair_en),
        .pair_ac (pair_ac)
    );

    scan_walker u_walk (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (restart),
        .plan    (plan),
        .emit    (emit)
    );

    assign ch_valid  = emit.valid;
    assign ch_tag    = emit.tag;
    assign scan_wrap = emit.wrap;
    assign mode_bad  = !plan.legal;

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk
    import scan_seq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [15:0] cfg_wdata,
    input logic        tick,
    input logic        ch_valid,
    input logic        scan_wrap,
    input logic        mode_bad,
    input logic [1:0]  pair_en,
    input logic [1:0]  pair_ac
);

    // R11
    idle_no_emit_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !ch_valid);

    // R6
    bad_mode_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_bad && !$past(cfg_we)) |-> !ch_valid);

    // R8
    wrap_needs_emit_chk: assert property (@(posedge clk) disable iff (rst)
        scan_wrap |-> ch_valid);

    // R9
    en_load_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (pair_en == $past(cfg_wdata[EN_LSB +: NUM_PAIRS])));

    // R9
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(pair_en));

    // R10
    ac_load_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (pair_ac == $past(cfg_wdata[AC_LSB +: NUM_PAIRS])));

    // R10
    ac_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(pair_ac));

endmodule

bind scan_seq scan_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .tick      (tick),
    .ch_valid  (ch_valid),
    .scan_wrap (scan_wrap),
    .mode_bad  (mode_bad),
    .pair_en   (pair_en),
    .pair_ac   (pair_ac)
);

// File: tb/test_scan_seq.sv
module test_scan_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        tick = 1'b0;
    logic        ch_valid, scan_wrap, mode_bad;
    logic [1:0]  ch_tag, pair_en, pair_ac;

    int tests = 0;
    int fails = 0;

    int    order[$];
    int    idx = 0;
    int    e_valid = 0, e_tag = 0, e_wrap = 0, e_bad = 1, e_en = 0, e_ac = 0;
    string e_req = "R6";

    always #5 clk = ~clk;

    scan_seq i_scan_seq (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tick(tick), .ch_valid(ch_valid), .ch_tag(ch_tag),
        .scan_wrap(scan_wrap), .mode_bad(mode_bad),
        .pair_en(pair_en), .pair_ac(pair_ac)
    );

    function automatic logic [15:0] cfgw(int code, int en, int ac);
        return {5'b0, ac[1:0], en[1:0], 4'b0, code[2:0]};
    endfunction

    task automatic check(string req, int act, int exp, string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: a queue holds the scan order
    always @(posedge clk) begin
        if (rst) begin
            order.delete();
            idx = 0; e_valid = 0; e_wrap = 0; e_tag = 0;
            e_bad = 1; e_en = 0; e_ac = 0; e_req = "R6";
        end else begin
            e_valid = (tick && order.size() > 0) ? 1 : 0;
            e_wrap  = 0;
            if (e_valid == 1) begin
                e_tag  = order[idx];
                e_wrap = (idx == order.size() - 1) ? 1 : 0;
                idx    = (e_wrap == 1) ? 0 : idx + 1;
            end
            if (cfg_we) begin
                int code;
                code = int'(cfg_wdata[2:0]);
                order.delete();
                if (code >= 4) begin
                    order.push_back(code % 4);
                    e_req = "R2";
                end else if (code == 1) begin
                    for (int c = 0; c < 4; c++) order.push_back(c);
                    e_req = "R5";
                end else if (code == 2) begin
                    order.push_back(0); order.push_back(1);
                    e_req = "R3";
                end else if (code == 3) begin
                    order.push_back(2); order.push_back(3);
                    e_req = "R4";
                end else begin
                    e_req = "R6";
                end
                idx   = 0;
                e_bad = (order.size() == 0) ? 1 : 0;
                e_en  = int'(cfg_wdata[8:7]);
                e_ac  = int'(cfg_wdata[10:9]);
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R11", int'(ch_valid), e_valid, "ch_valid");
            if (e_valid == 1) check(e_req, int'(ch_tag), e_tag, "ch_tag");
            check("R8", int'(scan_wrap), e_wrap, "scan_wrap");
            check("R6", int'(mode_bad), e_bad, "mode_bad");
            check("R9", int'(pair_en), e_en, "pair_en");
            check("R10", int'(pair_ac), e_ac, "pair_ac");
        end
    end

    task automatic step(logic we, logic [15:0] d, logic tk);
        @(negedge clk);
        cfg_we = we; cfg_wdata = d; tick = tk;
        @(posedge clk);
        #1;
        cfg_we = 1'b0; tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", int'(mode_bad), 1, "mode_bad in reset");
        check("R1", int'(ch_valid), 0, "ch_valid in reset");
        check("R1", int'(pair_en), 0, "pair_en in reset");
        @(negedge clk); rst = 1'b0;
        step(1'b0, '0, 1'b1);
        check("R1", int'(ch_valid), 0, "tick before any write");

        // R2 single channel 2
        step(1'b1, cfgw(6, 1, 2), 1'b0);
        for (int k = 0; k < 4; k++) begin
            step(1'b0, '0, 1'b1);
            check("R2", int'(ch_tag), 2, "single tag");
            check("R2", int'(scan_wrap), 1, "single wrap");
            step(1'b0, '0, 1'b0);
        end
        // R3 lower pair
        step(1'b1, cfgw(2, 3, 1), 1'b0);
        repeat (5) step(1'b0, '0, 1'b1);
        // R4 upper pair
        step(1'b1, cfgw(3, 2, 0), 1'b0);
        repeat (5) begin step(1'b0, '0, 1'b1); step(1'b0, '0, 1'b0); end
        // R5 all four
        step(1'b1, cfgw(1, 0, 3), 1'b0);
        repeat (9) step(1'b0, '0, 1'b1);
        // R6 idle code
        step(1'b1, cfgw(0, 1, 1), 1'b0);
        step(1'b0, '0, 1'b1);
        check("R6", int'(ch_valid), 0, "idle code emits");
        check("R6", int'(mode_bad), 1, "idle code flag");
        // R2 single channel 3
        step(1'b1, cfgw(7, 0, 0), 1'b0);
        repeat (3) step(1'b0, '0, 1'b1);

        // R7 rewrite mid-scan with a colliding tick
        step(1'b1, cfgw(1, 0, 0), 1'b0);
        repeat (3) step(1'b0, '0, 1'b1);
        step(1'b1, cfgw(2, 0, 0), 1'b1);
        check("R7", int'(ch_tag), 3, "colliding tick uses old mode");
        check("R7", int'(scan_wrap), 1, "colliding tick wrap");
        step(1'b0, '0, 1'b1);
        check("R7", int'(ch_tag), 0, "restart at first channel");
        step(1'b1, cfgw(1, 0, 0), 1'b0);
        step(1'b0, '0, 1'b1);
        step(1'b1, cfgw(1, 0, 0), 1'b0);
        step(1'b0, '0, 1'b1);
        check("R7", int'(ch_tag), 0, "same mode rewrite restarts");

        // mixed sweep
        for (int n = 0; n < 1500; n++) begin
            logic we;
            we = ($urandom_range(0, 9) == 0);
            step(we, 16'($urandom), 1'($urandom_range(0, 2) != 0));
        end

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule